// File: doc/BRIEF.md
# Event State Buffer Page Controller

This block is the memory-mapped side of a pair of two-bit event-state fields (a pending bit P in bit 1 and a queued bit Q in bit 0) kept for every event-queue descriptor. Each descriptor owns two adjacent pages in the address space. The even page of the pair reaches the notification field and the odd page reaches the escalation field. Software issues loads and stores at fixed offsets inside a page to query, force, trigger or end-of-interrupt the selected field. The block reads the field, computes its next value and writes it back only if it differs. A store that calls for forwarding produces a one-cycle notify pulse that carries the descriptor index and the page kind. Routing of that pulse is done elsewhere.

Requests enter on a valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the single read-response slot is empty or is being drained in the same cycle. Only loads produce a response. The response is held on `rsp_valid`/`rsp_rdata` without change until the edge on which `rsp_ready` is high. Stores finish when they are accepted. The page size is chosen by the `pg_shift` input and `desc_enable` marks which descriptors exist.

Top module: `esb_page_ctl`

## Requirements
- R1: After reset every field of every descriptor holds 01, `rsp_valid` and `notify_valid` are low and `req_ready` is high.
- R2: For `pg_shift` of 12 or 16 the descriptor index is the address shifted right by `pg_shift`+1. Address bit `pg_shift` selects the notification field when 0 and the escalation field when 1. Any other `pg_shift` makes every access invalid.
- R3: A load at page offset 0x800–0xBFF returns the field unchanged. Load data is a big-endian doubleword: the two-bit value sits in `rsp_rdata[57:56]` and every other bit is 0.
- R4: A load at offset 0xC00–0xFFF sets the field to offset bits [9:8] and returns the previous value.
- R5: A load at offset 0x000–0x7FF performs an end-of-interrupt and returns 1 if that end-of-interrupt calls for forwarding, 0 otherwise. It never pulses notify.
- R6: A store at offset 0x000–0x3FF triggers. 00 becomes 10 and forwards. 10 and 11 become 11 without forwarding. 01 stays 01 without forwarding.
- R7: A store at offset 0x400–0x7FF performs an end-of-interrupt. 11 becomes 10 and forwards. 00 and 10 become 00. 01 stays 01. Only 11 forwards.
- R8: A store at offset 0x800–0xBFF on a notification page forwards without changing the field. On an escalation page it has no effect.
- R9: A store at offset 0xC00–0xFFF, any access whose `req_size` is not 3 (8 bytes), and any access to an index at or above NUM_DESC or to a descriptor whose `desc_enable` bit is 0 is invalid. Such a load returns all ones and such a store changes nothing and does not notify.
- R10: A field is written only when its new value differs from its current value.
- R11: A forwarding store pulses `notify_valid` for exactly the cycle after its acceptance, with `notify_idx` and `notify_escal` naming its descriptor and page. A held response keeps its data stable and holds `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_shift | input | 5 | log2 of page size, 12 or 16 |
| desc_enable | input | NUM_DESC | Per-descriptor existence mask |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of access bytes |
| rsp_valid | output | 1 | Load response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 64 | Load response data |
| notify_valid | output | 1 | Forwarding pulse |
| notify_idx | output | IDX_W | Descriptor of the pulse |
| notify_escal | output | 1 | 1 if the pulse came from an escalation page |

## Verification
The assertions assume that `pg_shift` and `desc_enable` stay constant while requests are in flight and that request fields are stable from the cycle they are driven to acceptance. The stimulus changes configuration only when the block is idle and drives each request for a single accepted cycle. It keeps `rsp_ready` high except in one deliberate back-pressure episode, so every response is drained before the next load is issued. The sweep covers both page sizes, every descriptor, both pages, all four starting states and every offset window.

// File: rtl/esbp_pkg.sv
package esbp_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_GET, OP_SET, OP_LEOI, OP_TRIG, OP_SEOI, OP_INJ
  } esb_op_e;

  localparam logic [1:0] PQ_RESET = 2'b01;
endpackage

// File: rtl/esbp_decode.sv
module esbp_decode
  import esbp_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NUM_DESC = 4,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic [4:0]          pg_shift,
  input  logic [NUM_DESC-1:0] desc_enable,
  input  logic                is_write,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  output esb_op_e             op,
  output logic                acc_ok,
  output logic [IDX_W-1:0]    idx,
  output logic                escal,
  output logic [1:0]          set_val
);
  localparam int FULL_W = ADDR_W - 13;

  logic              sh16, shift_ok, in_range, enabled;
  logic [FULL_W-1:0] full_idx;
  logic [11:0]       off;
  logic              unused_low;

  assign sh16     = (pg_shift == 5'd16);
  assign shift_ok = sh16 || (pg_shift == 5'd12);
  assign full_idx = sh16 ? FULL_W'(addr[ADDR_W-1:17]) : addr[ADDR_W-1:13];
  assign escal    = sh16 ? addr[16] : addr[12];
  assign off      = addr[11:0];
  assign set_val  = off[9:8];
  assign idx      = full_idx[IDX_W-1:0];
  assign in_range = (full_idx < FULL_W'(NUM_DESC));
  assign enabled  = in_range && desc_enable[idx];
  assign unused_low = ^off[7:0];

  always_comb begin
    op = OP_NONE;
    if (!is_write) begin
      if (!off[11])            op = OP_LEOI;
      else if (!off[10])       op = OP_GET;
      else                     op = OP_SET;
    end else begin
      unique case (off[11:10])
        2'b00:   op = OP_TRIG;
        2'b01:   op = OP_SEOI;
        2'b10:   op = escal ? OP_NONE : OP_INJ;
        default: op = OP_NONE;
      endcase
    end
  end

  assign acc_ok = shift_ok && (size == 2'd3) && enabled && (op != OP_NONE);
endmodule

// File: rtl/esbp_pq_fsm.sv
module esbp_pq_fsm
  import esbp_pkg::*;
(
  input  esb_op_e    op,
  input  logic [1:0] pq_in,
  input  logic [1:0] set_val,
  output logic [1:0] pq_out,
  output logic       fwd
);
  logic [1:0] trig_pq, eoi_pq;
  logic       trig_fwd, eoi_fwd;

  always_comb begin
    unique case (pq_in)
      2'b00:   begin trig_pq = 2'b10; trig_fwd = 1'b1; end
      2'b01:   begin trig_pq = 2'b01; trig_fwd = 1'b0; end
      default: begin trig_pq = 2'b11; trig_fwd = 1'b0; end
    endcase
    unique case (pq_in)
      2'b11:   begin eoi_pq = 2'b10; eoi_fwd = 1'b1; end
      2'b01:   begin eoi_pq = 2'b01; eoi_fwd = 1'b0; end
      default: begin eoi_pq = 2'b00; eoi_fwd = 1'b0; end
    endcase
  end

  always_comb begin
    pq_out = pq_in;
    fwd    = 1'b0;
    unique case (op)
      OP_SET:          pq_out = set_val;
      OP_TRIG:         begin pq_out = trig_pq; fwd = trig_fwd; end
      OP_LEOI, OP_SEOI: begin pq_out = eoi_pq; fwd = eoi_fwd; end
      OP_INJ:          fwd = 1'b1;
      default:         ;
    endcase
  end
endmodule

// File: rtl/esbp_state.sv
module esbp_state
  import esbp_pkg::*;
#(
  parameter int NUM_DESC = 4,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_esc,
  output logic [1:0]       rd_pq,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_esc,
  input  logic [1:0]       wr_pq
);
  logic [1:0] pq_ntf [NUM_DESC];
  logic [1:0] pq_esc [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pq_ntf[g] <= PQ_RESET;
        pq_esc[g] <= PQ_RESET;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        if (wr_esc) pq_esc[g] <= wr_pq;
        else        pq_ntf[g] <= wr_pq;
      end
    end
  end

  assign rd_pq = rd_esc ? pq_esc[rd_idx] : pq_ntf[rd_idx];

  // R10: a write that lands must alter the stored field
  assert_wb_changed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_esc ? pq_esc[$past(wr_idx)] : pq_ntf[$past(wr_idx)]) != $past(rd_pq));
endmodule

// File: rtl/esb_page_ctl.sv
module esb_page_ctl
  import esbp_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NUM_DESC = 4,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          pg_shift,
  input  logic [NUM_DESC-1:0] desc_enable,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [63:0]         rsp_rdata,
  output logic                notify_valid,
  output logic [IDX_W-1:0]    notify_idx,
  output logic                notify_escal
);
  esb_op_e          op;
  logic             acc_ok, escal, fwd, accept, wr_en;
  logic [IDX_W-1:0] idx;
  logic [1:0]       set_val, pq_cur, pq_nxt, ret_val;

  esbp_decode #(.ADDR_W(ADDR_W), .NUM_DESC(NUM_DESC)) u_dec (
    .pg_shift(pg_shift), .desc_enable(desc_enable), .is_write(req_write),
    .addr(req_addr), .size(req_size), .op(op), .acc_ok(acc_ok),
    .idx(idx), .escal(escal), .set_val(set_val)
  );

  esbp_pq_fsm u_fsm (
    .op(op), .pq_in(pq_cur), .set_val(set_val), .pq_out(pq_nxt), .fwd(fwd)
  );

  esbp_state #(.NUM_DESC(NUM_DESC)) u_st (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_esc(escal), .rd_pq(pq_cur),
    .wr_en(wr_en), .wr_idx(idx), .wr_esc(escal), .wr_pq(pq_nxt)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && acc_ok && (pq_nxt != pq_cur);
  assign ret_val   = (op == OP_LEOI) ? {1'b0, fwd} : pq_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      notify_valid <= 1'b0;
      notify_idx   <= '0;
      notify_escal <= 1'b0;
    end else begin
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= acc_ok ? {6'b0, ret_val, 56'b0} : '1;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      notify_valid <= accept && req_write && acc_ok && fwd;
      if (accept && req_write) begin
        notify_idx   <= idx;
        notify_escal <= escal;
      end
    end
  end

  assert_notify_after_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(req_valid && req_ready && req_write));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_esc_inject_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && (req_addr[11:10] == 2'b10) &&
    ((pg_shift == 5'd16) ? req_addr[16] : req_addr[12]) |=> !notify_valid);

  assert_bad_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_write && (pg_shift != 5'd12) && (pg_shift != 5'd16)
    |=> rsp_rdata == '1);

  assert_trig_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && (req_addr[11:10] == 2'b00) && (pq_cur == 2'b01)
    |=> !notify_valid);
endmodule

// File: tb/esb_page_ctl_test.sv
module esb_page_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int ND = 4;

  logic          clk = 0, rst_n = 0;
  logic [4:0]    pg_shift = 5'd12;
  logic [ND-1:0] desc_enable = '1;
  logic          req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd3;
  logic          req_ready, rsp_valid, notify_valid, notify_escal;
  logic [63:0]   rsp_rdata;
  logic [1:0]    notify_idx;

  int n_chk = 0, n_fail = 0;
  logic [1:0] mdl [2][ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  esb_page_ctl #(.ADDR_W(AW), .NUM_DESC(ND)) uut (
    .clk(clk), .rst_n(rst_n), .pg_shift(pg_shift), .desc_enable(desc_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .notify_valid(notify_valid),
    .notify_idx(notify_idx), .notify_escal(notify_escal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int sh, int d, int pg, int off);
    int a;
    a = (d << (sh + 1)) | (pg << sh) | off;
    if (sh == 16) a = a | 'h5000;
    return AW'(a);
  endfunction

  function automatic logic [63:0] fmt(logic [1:0] v);
    return {6'b0, v, 56'b0};
  endfunction

  task automatic do_rd(input logic [AW-1:0] a, input logic [1:0] sz, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 0;
    d = rsp_valid ? rsp_rdata : 64'hBAD0_BAD0_BAD0_BAD0;
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [1:0] sz,
                       output logic nv, output logic [1:0] ni, output logic ne);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 0;
    nv = notify_valid; ni = notify_idx; ne = notify_escal;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic nv, ne;
    logic [1:0] ni, ep, ed;
    logic ef;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 notify", notify_valid, 0);
    check("R1 req_ready", req_ready, 1);
    for (int pg = 0; pg < 2; pg++)
      for (int dd = 0; dd < ND; dd++) mdl[pg][dd] = 2'b01;
    do_rd(mk(12, 3, 1, 'h800), 3, d);
    check("R1 reset field", d, fmt(2'b01));

    for (int shi = 0; shi < 2; shi++) begin
      int sh;
      sh = shi ? 16 : 12;
      pg_shift = 5'(sh);
      for (int dd = 0; dd < ND; dd++)
        for (int pg = 0; pg < 2; pg++)
          for (int s = 0; s < 4; s++)
            for (int opi = 0; opi < 6; opi++) begin
              do_rd(mk(sh, dd, pg, 'hC00 | (s << 8)), 3, d);
              check("R4 set returns previous", d, fmt(mdl[pg][dd]));
              ep = 2'(s); ef = 0;
              case (opi)
                0: begin
                  do_rd(mk(sh, dd, pg, 'h800 + 'h3F8), 3, d);
                  check("R3 get", d, fmt(2'(s)));
                end
                1: begin
                  if (s == 3) begin ep = 2; ef = 1; end
                  else if (s != 1) ep = 0;
                  do_rd(mk(sh, dd, pg, 'h000 + 'h7F8), 3, d);
                  check("R5 load eoi result", d, fmt({1'b0, ef}));
                  check("R5 no notify", notify_valid, 0);
                end
                2: begin
                  if (s == 0) begin ep = 2; ef = 1; end
                  else if (s != 1) ep = 3;
                  do_wr(mk(sh, dd, pg, 'h3F8), 3, nv, ni, ne);
                  check("R6 trigger notify", nv, ef);
                  if (ef) check("R11 notify tag", {ni, ne}, {2'(dd), 1'(pg)});
                end
                3: begin
                  if (s == 3) begin ep = 2; ef = 1; end
                  else if (s != 1) ep = 0;
                  do_wr(mk(sh, dd, pg, 'h500), 3, nv, ni, ne);
                  check("R7 store eoi notify", nv, ef);
                  if (ef) check("R11 notify tag", {ni, ne}, {2'(dd), 1'(pg)});
                end
                4: begin
                  ef = (pg == 0);
                  do_wr(mk(sh, dd, pg, 'h800), 3, nv, ni, ne);
                  check("R8 inject notify", nv, ef);
                end
                default: begin
                  do_wr(mk(sh, dd, pg, 'hC00 | (s << 8)), 3, nv, ni, ne);
                  check("R9 unmapped store notify", nv, 0);
                end
              endcase
              mdl[pg][dd] = ep;
              do_rd(mk(sh, dd, pg, 'h800), 3, d);
              check("R10 field after op (R2 page select)", d, fmt(ep));
            end
    end

    // R2: invalid page shift
    pg_shift = 5'd14;
    do_rd(mk(12, 0, 0, 'h800), 3, d);
    check("R2 bad shift read", d, '1);
    do_wr(mk(12, 0, 0, 'h000), 3, nv, ni, ne);
    check("R2 bad shift store", nv, 0);
    pg_shift = 5'd12;
    do_rd(mk(12, 0, 0, 'h800), 3, d);
    check("R2 bad shift left field", d, fmt(mdl[0][0]));

    // R9: size, range, enable
    do_rd(mk(12, 1, 0, 'hC00), 3, d);
    mdl[0][1] = 0;
    do_rd(mk(12, 1, 0, 'h800), 2, d);
    check("R9 short read", d, '1);
    do_wr(mk(12, 1, 0, 'h000), 2, nv, ni, ne);
    check("R9 short store notify", nv, 0);
    do_rd(mk(12, 1, 0, 'h800), 3, d);
    check("R9 short store ignored", d, fmt(2'b00));
    do_rd(mk(12, 4, 0, 'h800), 3, d);
    check("R9 index out of range", d, '1);
    desc_enable = 4'b1101;
    do_rd(mk(12, 1, 0, 'h800), 3, d);
    check("R9 disabled read", d, '1);
    do_wr(mk(12, 1, 0, 'h000), 3, nv, ni, ne);
    check("R9 disabled store", nv, 0);
    desc_enable = '1;
    do_rd(mk(12, 1, 0, 'h800), 3, d);
    check("R9 disabled store ignored", d, fmt(2'b00));

    // R11: back-pressure on the response
    rsp_ready = 0;
    do_rd(mk(12, 1, 0, 'h800), 3, d);
    check("R11 held rsp data", d, fmt(2'b00));
    check("R11 ready low while held", req_ready, 0);
    @(negedge clk);
    check("R11 still valid", rsp_valid, 1);
    check("R11 stable data", rsp_rdata, fmt(2'b00));
    rsp_ready = 1;
    @(negedge clk);
    check("R11 drained", rsp_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule